// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This unit lets an 8-bit microcontroller core read constant data stored in its wider program memory. Software first writes a table pointer register in the data-memory register space. It then issues a table read instruction by pulsing a strobe.

In the strobe cycle the unit takes over the program-memory address port:
- It drives the pointer onto that port instead of the program counter.
- It raises a stall so that the core holds its program counter.

In the following cycle the fetched word is split into two parts:
- The low 8 bits go out on the destination write port.
- The bits above them, zero-extended to 8, are latched in a read-only high-byte register. Software reads that register later through the same register port.

Every table read takes two cycles. Each one replaces the high-byte register, so software must copy that register before issuing another table read. Strobes in consecutive cycles are accepted, and their fetch and write phases overlap.

Top module: `tblrd_unit`

## Requirements
- R1: After the active-low reset, the pointer register (address 07H) and the high-byte register (address 08H) both read 00H, and stall_o and dst_we_o are 0.
- R2: A register write to address 07H loads the pointer. From the next cycle the register port reads the new value at address 07H.
- R3: A register write to address 08H has no effect. The high-byte register and the pointer keep their values.
- R4: In a cycle with tbrd_i high, stall_o is 1 and pm_addr_o equals the pointer zero-extended to PM_AW bits.
- R5: In a cycle with tbrd_i low, stall_o is 0 and pm_addr_o equals pc_i.
- R6: In the cycle after a strobe, dst_we_o is 1 and dst_data_o equals bits [7:0] of the program word at the pointer address. In every other cycle dst_we_o is 0.
- R7: After the write cycle, address 08H reads bits [PM_DW-1:8] of that word, zero-extended to 8 bits. During the write cycle it still reads the previous value.
- R8: Strobes in consecutive cycles each deliver their own word in order, and the high-byte register ends up holding the word of the latest read.
- R9: A pointer write in the same cycle as a strobe does not affect that fetch, which uses the old pointer. The new value applies from the next cycle.
- R10: Register reads of any address other than 07H and 08H return 00H and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register-file write enable |
| reg_addr_i | input | RA_W | Register-file address |
| reg_wdata_i | input | 8 | Register-file write data |
| reg_rdata_o | output | 8 | Register-file read data (combinational) |
| tbrd_i | input | 1 | Table read instruction strobe, one cycle per instruction |
| pc_i | input | PM_AW | Program counter from the core |
| pm_addr_o | output | PM_AW | Program-memory address |
| pm_rdata_i | input | PM_DW | Program-memory data, valid one cycle after the address |
| stall_o | output | 1 | Hold the program counter this cycle |
| dst_we_o | output | 1 | Destination write enable for the low byte |
| dst_data_o | output | 8 | Low byte of the fetched word |

## Verification
The main pattern sweeps every one of the 256 pointer values over a program memory whose content is a computed function of the address. This pattern separates pointer routing errors from errors in splitting the word, and a 14-bit word exposes faults in zero-extending the high part. During each write cycle the high-byte register is read back and must still hold the previous result. This reveals whether the register is updated in the correct cycle.

A second pattern issues two strobes in consecutive cycles and changes the pointer during the first of them. It separates the value that pointer sampled by the fetch from the value written in the same cycle, and it checks that the second high byte overwrites the first. Further patterns are a write attempt to the read-only address and reads of unmapped addresses. Both are checked afterwards through the register port.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t TP_ADDR_DEF = 8'h07;
  localparam byte_t TH_ADDR_DEF = 8'h08;
endpackage

// File: rtl/tblrd_regs.sv
module tblrd_regs
  import tblrd_pkg::*;
#(
  parameter int unsigned RA_W    = 8,
  parameter logic [RA_W-1:0] TP_ADDR = RA_W'(TP_ADDR_DEF),
  parameter logic [RA_W-1:0] TH_ADDR = RA_W'(TH_ADDR_DEF)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RA_W-1:0] reg_addr_i,
  input  byte_t           reg_wdata_i,
  output byte_t           reg_rdata_o,
  input  logic            hb_ld_i,
  input  byte_t           hb_i,
  output byte_t           tp_o
);
  byte_t tp_q, hb_q;
  logic  tp_we;

  assign tp_we = reg_we_i && (reg_addr_i == TP_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tp_q <= '0;
    else if (tp_we) tp_q <= reg_wdata_i;
  end

  // high byte: loaded only by a table read, never by the register port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hb_q <= '0;
    else if (hb_ld_i) hb_q <= hb_i;
  end

  always_comb begin
    if (reg_addr_i == TP_ADDR)      reg_rdata_o = tp_q;
    else if (reg_addr_i == TH_ADDR) reg_rdata_o = hb_q;
    else                            reg_rdata_o = '0;
  end

  assign tp_o = tp_q;

  // R2
  tp_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tp_we |=> tp_q == $past(reg_wdata_i));
  // R3
  hb_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hb_ld_i |=> $stable(hb_q));
  // R7
  hb_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hb_ld_i |=> hb_q == $past(hb_i));
endmodule

// File: rtl/tblrd_seq.sv
module tblrd_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tbrd_i,
  output logic stall_o,
  output logic wr_o
);
  logic wr_q;

  // fetch phase is the strobe cycle; write phase follows it
  assign stall_o = tbrd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= tbrd_i;
  end

  assign wr_o = wr_q;

  // R6
  wr_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> wr_o);
  // R6
  wr_only_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> !wr_o);
endmodule

// File: rtl/tblrd_split.sv
module tblrd_split
  import tblrd_pkg::*;
#(
  parameter int unsigned PM_DW = 16
) (
  input  logic [PM_DW-1:0] word_i,
  output byte_t            lo_o,
  output byte_t            hi_o
);
  localparam int unsigned HI_W = PM_DW - BYTE_W;

  assign lo_o = word_i[BYTE_W-1:0];

  generate
    if (HI_W >= BYTE_W) begin : g_full
      assign hi_o = word_i[BYTE_W+BYTE_W-1:BYTE_W];
    end else begin : g_zext
      assign hi_o = {{(BYTE_W-HI_W){1'b0}}, word_i[PM_DW-1:BYTE_W]};
    end
  endgenerate
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int unsigned PM_AW = 12,
  parameter int unsigned PM_DW = 16,
  parameter int unsigned RA_W  = 8,
  parameter logic [RA_W-1:0] TP_ADDR = RA_W'(TP_ADDR_DEF),
  parameter logic [RA_W-1:0] TH_ADDR = RA_W'(TH_ADDR_DEF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic             tbrd_i,
  input  logic [PM_AW-1:0] pc_i,
  output logic [PM_AW-1:0] pm_addr_o,
  input  logic [PM_DW-1:0] pm_rdata_i,
  output logic             stall_o,
  output logic             dst_we_o,
  output logic [7:0]       dst_data_o
);
  byte_t tp, lo, hi;
  logic  wr;

  tblrd_regs #(
    .RA_W   (RA_W),
    .TP_ADDR(TP_ADDR),
    .TH_ADDR(TH_ADDR)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .hb_ld_i    (wr),
    .hb_i       (hi),
    .tp_o       (tp)
  );

  tblrd_seq u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tbrd_i (tbrd_i),
    .stall_o(stall_o),
    .wr_o   (wr)
  );

  tblrd_split #(.PM_DW(PM_DW)) u_split (
    .word_i(pm_rdata_i),
    .lo_o  (lo),
    .hi_o  (hi)
  );

  // fetch port steals the address from the core during the strobe cycle
  assign pm_addr_o  = stall_o ? PM_AW'(tp) : pc_i;
  assign dst_we_o   = wr;
  assign dst_data_o = lo;

  // R5
  pc_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tbrd_i |-> (pm_addr_o == pc_i && !stall_o));
  // R6
  dst_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_we_o |-> dst_data_o == pm_rdata_i[7:0]);
endmodule

// File: tb/sim_tblrd_unit.sv
module sim_tblrd_unit;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          tbrd = 1'b0;
  logic [AW-1:0] pc = '0;
  logic [AW-1:0] pm_addr;
  logic [DW-1:0] pm_rdata;
  logic          stall, dst_we;
  logic [7:0]    dst_data;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    int v;
    v = (int'(a) * 157 + 91) ^ (int'(a) << 5);
    return v[DW-1:0];
  endfunction

  function automatic logic [7:0] lo_of(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = word_of(a);
    return w[7:0];
  endfunction

  function automatic logic [7:0] hi_of(input logic [AW-1:0] a);
    logic [DW-1:0] w;
    w = word_of(a);
    return {2'b00, w[DW-1:8]};
  endfunction

  // registered program memory model
  always_ff @(posedge clk) pm_rdata <= word_of(pm_addr);

  tblrd_unit #(.PM_AW(AW), .PM_DW(DW)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (reg_we),
    .reg_addr_i (reg_addr),
    .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .tbrd_i     (tbrd),
    .pc_i       (pc),
    .pm_addr_o  (pm_addr),
    .pm_rdata_i (pm_rdata),
    .stall_o    (stall),
    .dst_we_o   (dst_we),
    .dst_data_o (dst_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input int exp);
    reg_addr = a;
    #1;
    chk(req, int'(reg_rdata), exp);
  endtask

  logic [7:0] prev_hi;

  task automatic one_read(input logic [7:0] p);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h07; reg_wdata = p; pc = AW'(12'h5A0) + AW'(p);
    @(negedge clk);
    reg_we = 1'b0; tbrd = 1'b1;
    #2;
    chk("R4 stall", int'(stall), 1);
    chk("R4 addr", int'(pm_addr), int'(p));
    rd(8'h07, "R2 ptr", int'(p));
    @(negedge clk);
    tbrd = 1'b0;
    #2;
    chk("R6 we", int'(dst_we), 1);
    chk("R6 lo", int'(dst_data), int'(lo_of(AW'(p))));
    chk("R5 stall", int'(stall), 0);
    chk("R5 addr", int'(pm_addr), int'(pc));
    rd(8'h08, "R7 old", int'(prev_hi));
    @(negedge clk);
    #2;
    chk("R6 idle", int'(dst_we), 0);
    rd(8'h08, "R7 new", int'(hi_of(AW'(p))));
    prev_hi = hi_of(AW'(p));
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    prev_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1
    chk("R1 stall", int'(stall), 0);
    chk("R1 we", int'(dst_we), 0);
    rd(8'h07, "R1 ptr", 0);
    rd(8'h08, "R1 hb", 0);

    // R2 R4 R5 R6 R7: full pointer sweep
    for (int p = 0; p < 256; p++) one_read(8'(p));

    // R3: write to the read-only address
    one_read(8'h3C);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 8'h08; reg_wdata = ~prev_hi;
    @(negedge clk);
    reg_we = 1'b0;
    #2;
    rd(8'h08, "R3 hb", int'(prev_hi));
    rd(8'h07, "R3 ptr", 8'h3C);

    // R10: unmapped reads return zero and disturb nothing
    rd(8'h05, "R10 rd05", 0);
    rd(8'h00, "R10 rd00", 0);
    rd(8'hFF, "R10 rdFF", 0);
    rd(8'h08, "R10 hb", int'(prev_hi));
    rd(8'h07, "R10 ptr", 8'h3C);

    // R8 R9: back-to-back strobes, pointer rewritten in the first
    @(negedge clk);
    tbrd = 1'b1; reg_we = 1'b1; reg_addr = 8'h07; reg_wdata = 8'hC5;
    #2;
    chk("R9 addr", int'(pm_addr), 8'h3C);
    @(negedge clk);
    reg_we = 1'b0; tbrd = 1'b1;
    #2;
    chk("R8 stall", int'(stall), 1);
    chk("R9 newaddr", int'(pm_addr), 8'hC5);
    chk("R8 we1", int'(dst_we), 1);
    chk("R8 lo1", int'(dst_data), int'(lo_of(AW'(8'h3C))));
    @(negedge clk);
    tbrd = 1'b0;
    #2;
    chk("R8 we2", int'(dst_we), 1);
    chk("R8 lo2", int'(dst_data), int'(lo_of(AW'(8'hC5))));
    rd(8'h08, "R8 hb1", int'(hi_of(AW'(8'h3C))));
    @(negedge clk);
    #2;
    chk("R8 idle", int'(dst_we), 0);
    rd(8'h08, "R8 hb2", int'(hi_of(AW'(8'hC5))));
    rd(8'h07, "R9 ptr", 8'hC5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule